// File: doc/BRIEF.md
# Key-Guarded Auxiliary External-Data RAM

This block is a 256-byte scratch store that sits on the external-data path of an 8051-style core. It is placed between the MOVX request issued by the core and the external bus controller. For each request it decides whether the access is served on chip. When the access is served on chip, the block produces the read byte or takes the write byte. When it is not, the block raises a flag that sends the access out to the external bus.

The store is switched off after reset. It is switched on by one bit of a configuration register on the special-function-register (SFR) write bus. That register only accepts writes after a two-byte key has been written to a separate key register. While the store is on, every MOVX that uses an 8-bit register pointer stays inside the block. A 16-bit-pointer MOVX also stays inside when its address is at most 00FFh. While the store is off, every MOVX goes out to the external bus.

Top module: `aux_xram_top`

## Requirements
- R1: After reset, the store is off and the configuration register is locked. `xRdData` reads 00h, and any MOVX raises `xExtAccess`.
- R2: Two writes to SFR address F6h, 87h followed by 59h, unlock the configuration register at SFR address BFh. A write to BFh while it is unlocked sets the store enable to bit 4 of the written byte.
- R3: A write to F6h that is out of order clears the key progress. A stray 87h counts as the first key byte again. Writes to other SFR addresses between the two key bytes do not disturb the key progress.
- R4: Writing 00h to F6h locks the configuration register again. Any other value written once the key is complete leaves it unlocked.
- R5: A write to BFh while it is locked is ignored, and the store enable keeps its value.
- R6: While the store is off, every MOVX raises `xExtAccess` and leaves the store contents unchanged.
- R7: While the store is on, a MOVX with `xShortPtr`=1 never raises `xExtAccess`. It addresses the byte given by `xAddr[7:0]`, whatever `xAddr[15:8]` holds.
- R8: While the store is on, a MOVX with `xShortPtr`=0 is served inside when `xAddr[15:8]` is 00h. Otherwise it raises `xExtAccess` and does not touch the store.
- R9: An internal read shows its byte on `xRdData` one clock after the request. An internal write stores its byte on the request edge, so a read in the next cycle returns it. `xRdData` holds its value in every cycle that has no internal read.
- R10: A change of the store enable takes effect from the cycle after the write to BFh. A MOVX in the same cycle as that write is routed by the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR write address |
| sfrWrData | input | 8 | SFR write data |
| xReq | input | 1 | MOVX request valid |
| xAddr | input | 16 | MOVX address |
| xShortPtr | input | 1 | 1: 8-bit register pointer, 0: 16-bit data pointer |
| xWrite | input | 1 | 1: write, 0: read |
| xWrData | input | 8 | MOVX write data |
| xRdData | output | 8 | Read data, valid one clock after an internal read |
| xExtAccess | output | 1 | The current MOVX must go to the external bus |

## Verification
A write to the configuration register and a MOVX can arrive in the same cycle. That collision decides which enable setting routes the access. The bench provokes it in both directions. In one case it disables the store while an internal read is issued, and checks that the read is still served inside and returns the stored byte. In the other case it enables the store while a write is issued, and checks that the write goes outside. A later internal read then confirms that the write did not land in the store.

// File: rtl/aux_xram_pkg.sv
package aux_xram_pkg;

  parameter int unsigned AUX_IDX_W  = 8;
  parameter int unsigned AUX_DATA_W = 8;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } keyState_t;

  typedef struct packed {
    logic                 wrStb;
    logic                 rdStb;
    logic [AUX_IDX_W-1:0] idx;
  } ramStb_t;

endpackage

// File: rtl/aux_xram_key.sv
module aux_xram_key
  import aux_xram_pkg::*;
#(
  parameter int unsigned         SFR_AW    = 8,
  parameter int unsigned         DATA_W    = 8,
  parameter logic [SFR_AW-1:0]   KEY_ADDR  = 'hF6,
  parameter logic [DATA_W-1:0]   KEY_A     = 'h87,
  parameter logic [DATA_W-1:0]   KEY_B     = 'h59,
  parameter logic [DATA_W-1:0]   KEY_CLOSE = 'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWrData,
  output logic              cfgOpen
);

  keyState_t keyState, keyNext;
  logic      keyWr;

  assign keyWr = sfrWrEn && (sfrAddr == KEY_ADDR);

  always_comb begin
    keyNext = keyState;
    if (keyWr) begin
      if (sfrWrData == KEY_CLOSE) begin
        keyNext = KEY_IDLE;
      end else begin
        unique case (keyState)
          KEY_IDLE: keyNext = (sfrWrData == KEY_A) ? KEY_HALF : KEY_IDLE;
          KEY_HALF: begin
            if (sfrWrData == KEY_B)      keyNext = KEY_OPEN;
            else if (sfrWrData == KEY_A) keyNext = KEY_HALF;
            else                         keyNext = KEY_IDLE;
          end
          KEY_OPEN: keyNext = KEY_OPEN;
          default:  keyNext = KEY_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_IDLE;
    else       keyState <= keyNext;
  end

  assign cfgOpen = (keyState == KEY_OPEN);

endmodule

// File: rtl/aux_xram_ctrl.sv
module aux_xram_ctrl
  import aux_xram_pkg::*;
#(
  parameter int unsigned         SFR_AW    = 8,
  parameter int unsigned         XADDR_W   = 16,
  parameter logic [SFR_AW-1:0]   KEY_ADDR  = 'hF6,
  parameter logic [SFR_AW-1:0]   CFG_ADDR  = 'hBF,
  parameter int unsigned         EN_BIT    = 4,
  parameter logic [AUX_DATA_W-1:0] KEY_A   = 'h87,
  parameter logic [AUX_DATA_W-1:0] KEY_B   = 'h59,
  parameter logic [AUX_DATA_W-1:0] KEY_CLOSE = 'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sfrWrEn,
  input  logic [SFR_AW-1:0]     sfrAddr,
  input  logic [AUX_DATA_W-1:0] sfrWrData,
  input  logic                  xReq,
  input  logic [XADDR_W-1:0]    xAddr,
  input  logic                  xShortPtr,
  input  logic                  xWrite,
  output ramStb_t               stb,
  output logic                  xExtAccess,
  output logic                  ramEn,
  output logic                  cfgOpen
);

  localparam int unsigned HI_W = XADDR_W - AUX_IDX_W;

  logic cfgWr;
  logic lowPage;
  logic hit;

  aux_xram_key #(
    .SFR_AW   (SFR_AW),
    .DATA_W   (AUX_DATA_W),
    .KEY_ADDR (KEY_ADDR),
    .KEY_A    (KEY_A),
    .KEY_B    (KEY_B),
    .KEY_CLOSE(KEY_CLOSE)
  ) u_key (
    .clk      (clk),
    .rstN     (rstN),
    .sfrWrEn  (sfrWrEn),
    .sfrAddr  (sfrAddr),
    .sfrWrData(sfrWrData),
    .cfgOpen  (cfgOpen)
  );

  assign cfgWr = sfrWrEn && (sfrAddr == CFG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ramEn <= 1'b0;
    else if (cfgWr && cfgOpen) ramEn <= sfrWrData[EN_BIT];
  end

  assign lowPage    = (xAddr[XADDR_W-1 -: HI_W] == '0);
  assign hit        = ramEn && xReq && (xShortPtr || lowPage);
  assign xExtAccess = xReq && !hit;

  always_comb begin
    stb.wrStb = hit && xWrite;
    stb.rdStb = hit && !xWrite;
    stb.idx   = xAddr[AUX_IDX_W-1:0];
  end

endmodule

// File: rtl/aux_xram_store.sv
module aux_xram_store
  import aux_xram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ramStb_t               stb,
  input  logic [AUX_DATA_W-1:0] wrData,
  output logic [AUX_DATA_W-1:0] rdData
);

  localparam int unsigned DEPTH = 1 << AUX_IDX_W;

  logic [AUX_DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[stb.idx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= mem[stb.idx];
  end

endmodule

// File: rtl/aux_xram_top.sv
module aux_xram_top
  import aux_xram_pkg::*;
#(
  parameter int unsigned           SFR_AW    = 8,
  parameter int unsigned           XADDR_W   = 16,
  parameter logic [SFR_AW-1:0]     KEY_ADDR  = 'hF6,
  parameter logic [SFR_AW-1:0]     CFG_ADDR  = 'hBF,
  parameter int unsigned           EN_BIT    = 4,
  parameter logic [AUX_DATA_W-1:0] KEY_A     = 'h87,
  parameter logic [AUX_DATA_W-1:0] KEY_B     = 'h59,
  parameter logic [AUX_DATA_W-1:0] KEY_CLOSE = 'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sfrWrEn,
  input  logic [SFR_AW-1:0]     sfrAddr,
  input  logic [AUX_DATA_W-1:0] sfrWrData,
  input  logic                  xReq,
  input  logic [XADDR_W-1:0]    xAddr,
  input  logic                  xShortPtr,
  input  logic                  xWrite,
  input  logic [AUX_DATA_W-1:0] xWrData,
  output logic [AUX_DATA_W-1:0] xRdData,
  output logic                  xExtAccess
);

  ramStb_t stb;
  logic    ramEn;
  logic    cfgOpen;

  aux_xram_ctrl #(
    .SFR_AW   (SFR_AW),
    .XADDR_W  (XADDR_W),
    .KEY_ADDR (KEY_ADDR),
    .CFG_ADDR (CFG_ADDR),
    .EN_BIT   (EN_BIT),
    .KEY_A    (KEY_A),
    .KEY_B    (KEY_B),
    .KEY_CLOSE(KEY_CLOSE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sfrWrEn   (sfrWrEn),
    .sfrAddr   (sfrAddr),
    .sfrWrData (sfrWrData),
    .xReq      (xReq),
    .xAddr     (xAddr),
    .xShortPtr (xShortPtr),
    .xWrite    (xWrite),
    .stb       (stb),
    .xExtAccess(xExtAccess),
    .ramEn     (ramEn),
    .cfgOpen   (cfgOpen)
  );

  aux_xram_store u_store (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(xWrData),
    .rdData(xRdData)
  );

endmodule

// File: rtl/aux_xram_chk.sv
module aux_xram_chk #(
  parameter int unsigned     SFR_AW   = 8,
  parameter int unsigned     XADDR_W  = 16,
  parameter int unsigned     IDX_W    = 8,
  parameter int unsigned     DATA_W   = 8,
  parameter logic [SFR_AW-1:0] KEY_ADDR = 'hF6,
  parameter logic [SFR_AW-1:0] CFG_ADDR = 'hBF,
  parameter logic [DATA_W-1:0] KEY_B    = 'h59,
  parameter logic [DATA_W-1:0] KEY_CLOSE = 'h00
) (
  input logic               clk,
  input logic               rstN,
  input logic               sfrWrEn,
  input logic [SFR_AW-1:0]  sfrAddr,
  input logic [DATA_W-1:0]  sfrWrData,
  input logic               xReq,
  input logic [XADDR_W-1:0] xAddr,
  input logic               xShortPtr,
  input logic               xWrite,
  input logic [DATA_W-1:0]  xRdData,
  input logic               xExtAccess,
  input logic               ramEn,
  input logic               cfgOpen
);

  localparam int unsigned HI_W = XADDR_W - IDX_W;

  logic keyWr, cfgWr, highAddr, intRead;
  assign keyWr    = sfrWrEn && (sfrAddr == KEY_ADDR);
  assign cfgWr    = sfrWrEn && (sfrAddr == CFG_ADDR);
  assign highAddr = (xAddr[XADDR_W-1 -: HI_W] != '0);
  assign intRead  = xReq && !xWrite && !xExtAccess;

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!ramEn && !cfgOpen));

  p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(keyWr && (sfrWrData == KEY_B)));

  p_close_locks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && (sfrWrData == KEY_CLOSE)) |=> !cfgOpen);

  p_locked_cfg_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgOpen) |=> $stable(ramEn));

  p_off_goes_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ramEn && xReq) |-> xExtAccess);

  p_short_stays_in_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && xReq && xShortPtr) |-> !xExtAccess);

  p_high_goes_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xReq && !xShortPtr && highAddr) |-> xExtAccess);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !intRead |=> $stable(xRdData));

  p_no_req_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !xReq |-> !xExtAccess);

endmodule

bind aux_xram_top aux_xram_chk #(
  .SFR_AW   (SFR_AW),
  .XADDR_W  (XADDR_W),
  .IDX_W    (aux_xram_pkg::AUX_IDX_W),
  .DATA_W   (aux_xram_pkg::AUX_DATA_W),
  .KEY_ADDR (KEY_ADDR),
  .CFG_ADDR (CFG_ADDR),
  .KEY_B    (KEY_B),
  .KEY_CLOSE(KEY_CLOSE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sfrWrEn   (sfrWrEn),
  .sfrAddr   (sfrAddr),
  .sfrWrData (sfrWrData),
  .xReq      (xReq),
  .xAddr     (xAddr),
  .xShortPtr (xShortPtr),
  .xWrite    (xWrite),
  .xRdData   (xRdData),
  .xExtAccess(xExtAccess),
  .ramEn     (ramEn),
  .cfgOpen   (cfgOpen)
);

// File: tb/tb_aux_xram_top.sv
module tb_aux_xram_top;

  localparam logic [1:0] K_SFR = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;
    logic        shortP;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        expExt;
    logic [7:0]  expData;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{4'd6, K_RD,  1'b1, 16'h0012, 8'h00, 1'b1, 8'h00}, // R6 off after reset
    '{4'd5, K_SFR, 1'b0, 16'h00BF, 8'h10, 1'b0, 8'h00}, // R5 locked write
    '{4'd5, K_WR,  1'b1, 16'h0012, 8'h34, 1'b1, 8'h00}, // R5 still off
    '{4'd2, K_SFR, 1'b0, 16'h00F6, 8'h87, 1'b0, 8'h00}, // R2
    '{4'd2, K_SFR, 1'b0, 16'h00F6, 8'h59, 1'b0, 8'h00}, // R2
    '{4'd2, K_SFR, 1'b0, 16'h00BF, 8'h10, 1'b0, 8'h00}, // R2 enable
    '{4'd7, K_WR,  1'b1, 16'h0012, 8'h34, 1'b0, 8'h00}, // R7
    '{4'd7, K_RD,  1'b1, 16'h0012, 8'h00, 1'b0, 8'h34}, // R7
    '{4'd7, K_WR,  1'b1, 16'hAB12, 8'h56, 1'b0, 8'h00}, // R7 upper ignored
    '{4'd7, K_RD,  1'b1, 16'h0012, 8'h00, 1'b0, 8'h56}, // R7
    '{4'd8, K_WR,  1'b0, 16'h00FF, 8'h77, 1'b0, 8'h00}, // R8 top byte inside
    '{4'd8, K_RD,  1'b0, 16'h00FF, 8'h00, 1'b0, 8'h77}, // R8
    '{4'd8, K_WR,  1'b0, 16'h0112, 8'h99, 1'b1, 8'h00}, // R8 above FFh
    '{4'd8, K_RD,  1'b1, 16'h0012, 8'h00, 1'b0, 8'h56}, // R8 untouched
    '{4'd9, K_WR,  1'b1, 16'h0040, 8'hA5, 1'b0, 8'h00}, // R9
    '{4'd9, K_RD,  1'b1, 16'h0040, 8'h00, 1'b0, 8'hA5}, // R9 read after write
    '{4'd4, K_SFR, 1'b0, 16'h00F6, 8'h00, 1'b0, 8'h00}, // R4 close
    '{4'd4, K_SFR, 1'b0, 16'h00BF, 8'h00, 1'b0, 8'h00}, // R4 ignored
    '{4'd4, K_RD,  1'b1, 16'h0012, 8'h00, 1'b0, 8'h56}, // R4 still on
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h87, 1'b0, 8'h00}, // R3
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h12, 1'b0, 8'h00}, // R3 break
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h59, 1'b0, 8'h00}, // R3
    '{4'd3, K_SFR, 1'b0, 16'h00BF, 8'h00, 1'b0, 8'h00}, // R3 ignored
    '{4'd3, K_RD,  1'b1, 16'h0012, 8'h00, 1'b0, 8'h56}, // R3 still on
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h87, 1'b0, 8'h00}, // R3
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h87, 1'b0, 8'h00}, // R3 repeat first
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h59, 1'b0, 8'h00}, // R3 open
    '{4'd3, K_SFR, 1'b0, 16'h00BF, 8'h00, 1'b0, 8'h00}, // R3 disable
    '{4'd3, K_RD,  1'b1, 16'h0012, 8'h00, 1'b1, 8'h00}, // R3 off now
    '{4'd6, K_WR,  1'b1, 16'h0012, 8'hEE, 1'b1, 8'h00}, // R6 no store
    '{4'd6, K_RD,  1'b0, 16'h0012, 8'h00, 1'b1, 8'h00}, // R6
    '{4'd4, K_SFR, 1'b0, 16'h00F6, 8'h33, 1'b0, 8'h00}, // R4 stays open
    '{4'd4, K_SFR, 1'b0, 16'h00BF, 8'h10, 1'b0, 8'h00}, // R4 enable
    '{4'd6, K_RD,  1'b1, 16'h0012, 8'h00, 1'b0, 8'h56}, // R6 old byte kept
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h00, 1'b0, 8'h00}, // R3 close
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h87, 1'b0, 8'h00}, // R3
    '{4'd3, K_SFR, 1'b0, 16'h0080, 8'h55, 1'b0, 8'h00}, // R3 other SFR
    '{4'd3, K_SFR, 1'b0, 16'h00F6, 8'h59, 1'b0, 8'h00}, // R3 open
    '{4'd3, K_SFR, 1'b0, 16'h00BF, 8'h00, 1'b0, 8'h00}, // R3 disable
    '{4'd3, K_RD,  1'b1, 16'h0012, 8'h00, 1'b1, 8'h00}  // R3 off
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        sfrWrEn;
  logic [7:0]  sfrAddr, sfrWrData;
  logic        xReq, xShortPtr, xWrite;
  logic [15:0] xAddr;
  logic [7:0]  xWrData, xRdData;
  logic        xExtAccess;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aux_xram_top dut (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .xReq(xReq), .xAddr(xAddr), .xShortPtr(xShortPtr),
    .xWrite(xWrite), .xWrData(xWrData), .xRdData(xRdData), .xExtAccess(xExtAccess)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    sfrWrEn = 1'b0; sfrAddr = '0; sfrWrData = '0;
    xReq = 1'b0; xAddr = '0; xShortPtr = 1'b0; xWrite = 1'b0; xWrData = '0;
  endtask

  // One cycle: optional SFR write and optional MOVX, checked before and after the edge.
  task automatic step(input bit doSfr, input logic [7:0] sa, input logic [7:0] sd,
                      input bit doX, input bit sp, input bit wr,
                      input logic [15:0] a, input logic [7:0] d,
                      input bit expExt, input bit chkData, input logic [7:0] expD,
                      input int req);
    @(negedge clk);
    sfrWrEn = doSfr; sfrAddr = sa; sfrWrData = sd;
    xReq = doX; xShortPtr = sp; xWrite = wr; xAddr = a; xWrData = d;
    #2;
    if (doX) check(xExtAccess == expExt, req, "ext flag", {7'd0, xExtAccess}, {7'd0, expExt});
    @(posedge clk);
    #4;
    if (chkData) check(xRdData == expD, req, "read data", xRdData, expD);
    clearIn();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearIn();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: reset state
    check(xRdData == 8'h00, 1, "reset read data", xRdData, 8'h00);
    check(xExtAccess == 1'b0, 1, "idle ext flag", {7'd0, xExtAccess}, 8'h00);
    step(0, 8'h00, 8'h00, 1, 1, 0, 16'h0005, 8'h00, 1, 0, 8'h00, 1); // R1

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      if (v.kind == K_SFR)
        step(1, v.addr[7:0], v.data, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 8'h00, int'(v.req));
      else
        step(0, 8'h00, 8'h00, 1, v.shortP, (v.kind == K_WR), v.addr, v.data,
             v.expExt, (v.kind == K_RD) && !v.expExt, v.expData, int'(v.req));
    end

    // R9: read data holds without an internal read
    step(1, 8'hBF, 8'h10, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 8'h00, 9);
    step(0, 8'h00, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 0, 1, 8'h56, 9);
    step(0, 8'h00, 8'h00, 0, 0, 0, 16'h0000, 8'h00, 0, 1, 8'h56, 9);
    step(0, 8'h00, 8'h00, 1, 0, 0, 16'h0200, 8'h00, 1, 1, 8'h56, 9);
    step(0, 8'h00, 8'h00, 1, 1, 1, 16'h0077, 8'hC3, 0, 1, 8'h56, 9);

    // R10: enable change and MOVX in the same cycle
    step(1, 8'hBF, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 0, 1, 8'h56, 10);
    step(0, 8'h00, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 1, 0, 8'h00, 10);
    step(1, 8'hBF, 8'h10, 1, 1, 1, 16'h0012, 8'h11, 1, 0, 8'h00, 10);
    step(0, 8'h00, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 0, 1, 8'h56, 10);

    // R1: reset in mid-run clears enable, key state and read data
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #2;
    check(xRdData == 8'h00, 1, "read data after reset", xRdData, 8'h00);
    step(0, 8'h00, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 1, 0, 8'h00, 1);
    step(1, 8'hBF, 8'h10, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 8'h00, 1);
    step(0, 8'h00, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 1, 0, 8'h00, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule